// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This block sits next to a UART receiver and transmitter and handles the modem-style handshake lines. On the receive side it drives the request-to-send pin, either straight from a software bit or automatically from the receive buffer occupancy and the receiver's start-bit pulse. It also raises a level flag whenever the buffer holds at least the selected threshold number of words.

On the transmit side it synchronises the clear-to-send pin and applies a programmable polarity to form a CTS status bit. It then decides whether the transmitter may begin a new word. The decision is taken at word boundaries only, so a word that is already being shifted out always finishes. When automatic CTS gating is off, a software pause bit can stop new words in the same way.

Top module: `uart_flowctl`

## Requirements
- R1: The threshold is 2 words when `cfg_thr_sel`=0 and 4 words when it is 1. `rx_thr_flag` is a combinational level that is 1 exactly while `rx_count` is at or above the selected threshold.
- R2: With `cfg_auto_rts`=0, after each clock edge `rts_n` equals the inverse of the `cfg_manual_rts` value sampled at that edge. Manual 1 gives a low (asserted, ready) pin and manual 0 gives a high pin.
- R3: With `cfg_auto_rts`=1, a clock edge that samples `rx_start`=1 while `rx_count` is at or above the threshold drives `rts_n` high (deasserted) after that edge.
- R4: With `cfg_auto_rts`=1, a clock edge that samples `rx_count` below the threshold drives `rts_n` low. When `rx_count` is at or above the threshold and `rx_start` is 0, the edge leaves the automatic ready state unchanged.
- R5: During reset `rts_n` is 1. The automatic ready state resets to ready, so with automatic RTS on, a full buffer and no start pulse, `rts_n` goes low at the first edge after reset.
- R6: `cts_status` equals the `cts_pin` value sampled two clock edges earlier when `cfg_cts_pol`=1, and its inverse when `cfg_cts_pol`=0. The two synchroniser stages reset to 0.
- R7: With `cfg_auto_cts`=1, `tx_start` = `tx_pending` AND NOT `tx_busy` AND `cts_status`.
- R8: With `cfg_auto_cts`=0, `tx_start` = `tx_pending` AND NOT `tx_busy` AND NOT `cfg_tx_pause`, whatever the CTS level.
- R9: `tx_allow` is 1 whenever `tx_busy` is 1. When `tx_busy` is 0 it is 1 only if the gate of R7/R8 is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_manual_rts | input | 1 | Software RTS level (1 = ready) |
| cfg_auto_rts | input | 1 | Enable occupancy-driven RTS |
| cfg_auto_cts | input | 1 | Enable CTS gating of transmission |
| cfg_cts_pol | input | 1 | 1: status follows pin, 0: status is pin inverted |
| cfg_tx_pause | input | 1 | Software transmit pause, used when CTS gating is off |
| cfg_thr_sel | input | 1 | Threshold select: 0 = two words, 1 = four words |
| rx_count | input | CNT_W | Receive buffer occupancy |
| rx_start | input | 1 | One-cycle start-bit detected pulse |
| cts_pin | input | 1 | Asynchronous clear-to-send pin |
| tx_pending | input | 1 | Transmit data is waiting |
| tx_busy | input | 1 | A word is being shifted out |
| rts_n | output | 1 | Request-to-send pin, active low |
| cts_status | output | 1 | Synchronised CTS after polarity |
| tx_allow | output | 1 | Transmitter may run (busy, or gate open) |
| tx_start | output | 1 | Begin the next word this cycle |
| rx_thr_flag | output | 1 | Occupancy at or above threshold |

## Verification
A wrong automatic ready state shows on `rts_n` one edge after the sampled stimulus. A stuck state hides until the occupancy or a start pulse would have moved it, so the bench walks the count across both thresholds with and without start pulses. A wrong synchroniser depth or polarity shows on `cts_status`, and through it on `tx_start`, exactly two edges after a pin change. The reference model compares every output on every cycle, so any offset is caught within one cycle.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
   typedef enum logic {
      GATE_SOFT = 1'b0,
      GATE_CTS  = 1'b1
   } gate_mode_e;
endpackage

// File: rtl/flowctl_sync.sv
module flowctl_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("flowctl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q[i] <= RST_VAL;
         end else begin
            if (i == 0) chain_q[i] <= d;
            else        chain_q[i] <= chain_q[(i > 0) ? i-1 : 0];
         end
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/flowctl_rts.sv
module flowctl_rts #(
   parameter int CNT_W      = 5,
   parameter int THR_LO     = 2,
   parameter int THR_HI     = 4,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             manual_rdy,
   input  logic             auto_en,
   input  logic             thr_sel,
   input  logic [CNT_W-1:0] occ,
   input  logic             start_det,
   output logic             rts_pin,
   output logic             thr_flag
);
   localparam logic [CNT_W-1:0] THR_LO_C = CNT_W'(THR_LO);
   localparam logic [CNT_W-1:0] THR_HI_C = CNT_W'(THR_HI);

   if (THR_LO < 1 || THR_LO >= THR_HI) begin : g_bad_thr
      $error("flowctl_rts: need 1 <= THR_LO < THR_HI");
   end
   if (THR_HI >= (1 << CNT_W)) begin : g_bad_width
      $error("flowctl_rts: CNT_W too narrow for THR_HI");
   end

   logic [CNT_W-1:0] thr;
   logic             at_or_above;
   logic             auto_rdy_q;
   logic             auto_rdy_d;
   logic             lvl_q;

   assign thr         = thr_sel ? THR_HI_C : THR_LO_C;
   assign at_or_above = (occ >= thr);
   assign thr_flag    = at_or_above;

   always_comb begin
      auto_rdy_d = auto_rdy_q;
      if (!at_or_above)          auto_rdy_d = 1'b1;
      else if (start_det)        auto_rdy_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         auto_rdy_q <= 1'b1;
         lvl_q      <= 1'b0;
      end else begin
         auto_rdy_q <= auto_rdy_d;
         lvl_q      <= auto_en ? auto_rdy_d : manual_rdy;
      end
   end

   if (ACTIVE_LOW) begin : g_pin_low
      assign rts_pin = ~lvl_q;
   end else begin : g_pin_high
      assign rts_pin = lvl_q;
   end
endmodule

// File: rtl/flowctl_txgate.sv
module flowctl_txgate
   import flowctl_pkg::*;
(
   input  logic auto_cts,
   input  logic cts_st,
   input  logic sw_pause,
   input  logic pending,
   input  logic busy,
   output logic allow,
   output logic start
);
   gate_mode_e mode;
   logic       gate_open;

   assign mode = auto_cts ? GATE_CTS : GATE_SOFT;

   always_comb begin
      unique case (mode)
         GATE_CTS:  gate_open = cts_st;
         GATE_SOFT: gate_open = ~sw_pause;
         default:   gate_open = 1'b0;
      endcase
   end

   assign allow = busy | gate_open;
   assign start = pending & ~busy & gate_open;
endmodule

// File: rtl/uart_flowctl.sv
module uart_flowctl #(
   parameter int CNT_W       = 5,
   parameter int THR_LO      = 2,
   parameter int THR_HI      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit RTS_ACT_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_manual_rts,
   input  logic             cfg_auto_rts,
   input  logic             cfg_auto_cts,
   input  logic             cfg_cts_pol,
   input  logic             cfg_tx_pause,
   input  logic             cfg_thr_sel,
   input  logic [CNT_W-1:0] rx_count,
   input  logic             rx_start,
   input  logic             cts_pin,
   input  logic             tx_pending,
   input  logic             tx_busy,
   output logic             rts_n,
   output logic             cts_status,
   output logic             tx_allow,
   output logic             tx_start,
   output logic             rx_thr_flag
);
   logic cts_sync;

   flowctl_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cts_pin),
      .q     (cts_sync)
   );

   assign cts_status = cfg_cts_pol ? cts_sync : ~cts_sync;

   flowctl_rts #(
      .CNT_W      (CNT_W),
      .THR_LO     (THR_LO),
      .THR_HI     (THR_HI),
      .ACTIVE_LOW (RTS_ACT_LOW)
   ) u_rts (
      .clk        (clk),
      .rst_n      (rst_n),
      .manual_rdy (cfg_manual_rts),
      .auto_en    (cfg_auto_rts),
      .thr_sel    (cfg_thr_sel),
      .occ        (rx_count),
      .start_det  (rx_start),
      .rts_pin    (rts_n),
      .thr_flag   (rx_thr_flag)
   );

   flowctl_txgate u_gate (
      .auto_cts (cfg_auto_cts),
      .cts_st   (cts_status),
      .sw_pause (cfg_tx_pause),
      .pending  (tx_pending),
      .busy     (tx_busy),
      .allow    (tx_allow),
      .start    (tx_start)
   );
endmodule

// File: rtl/uart_flowctl_chk.sv
module uart_flowctl_chk #(
   parameter int CNT_W  = 5,
   parameter int THR_LO = 2,
   parameter int THR_HI = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_manual_rts,
   input logic             cfg_auto_rts,
   input logic             cfg_auto_cts,
   input logic             cfg_cts_pol,
   input logic             cfg_tx_pause,
   input logic             cfg_thr_sel,
   input logic [CNT_W-1:0] rx_count,
   input logic             rx_start,
   input logic             cts_pin,
   input logic             tx_pending,
   input logic             tx_busy,
   input logic             rts_n,
   input logic             cts_status,
   input logic             tx_allow,
   input logic             tx_start,
   input logic             rx_thr_flag
);
   logic       full_c;
   logic [1:0] age_q;

   assign full_c = cfg_thr_sel ? (int'(rx_count) >= THR_HI) : (int'(rx_count) >= THR_LO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age_q <= 2'd0;
      else if (age_q != 3) age_q <= age_q + 2'd1;
   end

   a_r1_flag_level: assert property (@(posedge clk) disable iff (!rst_n)
      rx_thr_flag == full_c);

   a_r2_manual_pin: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_auto_rts |=> rts_n == !$past(cfg_manual_rts));

   a_r3_auto_deassert: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_auto_rts && rx_start && full_c) |=> rts_n);

   a_r4_auto_reassert: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_auto_rts && !full_c) |=> !rts_n);

   a_r6_cts_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2) |-> cts_status == ($past(cts_pin, 2) ~^ cfg_cts_pol));

   a_r7_cts_block: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_auto_cts && !cts_status) |-> !tx_start);

   a_r8_pause_block: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_auto_cts && cfg_tx_pause) |-> !tx_start);

   a_r9_busy_allow: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |-> (tx_allow && !tx_start));
endmodule

bind uart_flowctl uart_flowctl_chk #(
   .CNT_W  (CNT_W),
   .THR_LO (THR_LO),
   .THR_HI (THR_HI)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_manual_rts (cfg_manual_rts),
   .cfg_auto_rts   (cfg_auto_rts),
   .cfg_auto_cts   (cfg_auto_cts),
   .cfg_cts_pol    (cfg_cts_pol),
   .cfg_tx_pause   (cfg_tx_pause),
   .cfg_thr_sel    (cfg_thr_sel),
   .rx_count       (rx_count),
   .rx_start       (rx_start),
   .cts_pin        (cts_pin),
   .tx_pending     (tx_pending),
   .tx_busy        (tx_busy),
   .rts_n          (rts_n),
   .cts_status     (cts_status),
   .tx_allow       (tx_allow),
   .tx_start       (tx_start),
   .rx_thr_flag    (rx_thr_flag)
);

// File: tb/uart_flowctl_bench.sv
module uart_flowctl_bench;
   localparam int CNT_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_manual_rts = 1'b0;
   logic             cfg_auto_rts = 1'b0;
   logic             cfg_auto_cts = 1'b0;
   logic             cfg_cts_pol = 1'b1;
   logic             cfg_tx_pause = 1'b0;
   logic             cfg_thr_sel = 1'b0;
   logic [CNT_W-1:0] rx_count = '0;
   logic             rx_start = 1'b0;
   logic             cts_pin = 1'b0;
   logic             tx_pending = 1'b0;
   logic             tx_busy = 1'b0;
   logic             rts_n;
   logic             cts_status;
   logic             tx_allow;
   logic             tx_start;
   logic             rx_thr_flag;

   int checks = 0;
   int errors = 0;

   // reference model state
   bit m_rts_n = 1'b1;
   bit m_ready = 1'b1;
   bit cts_hist[$] = '{1'b0, 1'b0};

   always #10 clk = ~clk;

   uart_flowctl u_uart_flowctl (
      .clk(clk), .rst_n(rst_n),
      .cfg_manual_rts(cfg_manual_rts), .cfg_auto_rts(cfg_auto_rts),
      .cfg_auto_cts(cfg_auto_cts), .cfg_cts_pol(cfg_cts_pol),
      .cfg_tx_pause(cfg_tx_pause), .cfg_thr_sel(cfg_thr_sel),
      .rx_count(rx_count), .rx_start(rx_start), .cts_pin(cts_pin),
      .tx_pending(tx_pending), .tx_busy(tx_busy),
      .rts_n(rts_n), .cts_status(cts_status), .tx_allow(tx_allow),
      .tx_start(tx_start), .rx_thr_flag(rx_thr_flag)
   );

   function automatic int thr_now();
      return cfg_thr_sel ? 4 : 2;
   endfunction

   always @(posedge clk) begin
      bit full;
      bit nxt;
      full = int'(rx_count) >= thr_now();
      if (!rst_n) begin
         m_rts_n <= 1'b1;
         m_ready <= 1'b1;
         cts_hist = '{1'b0, 1'b0};
      end else begin
         nxt = m_ready;
         if (!full) nxt = 1'b1;
         else if (rx_start) nxt = 1'b0;
         m_ready <= nxt;
         m_rts_n <= cfg_auto_rts ? !nxt : !cfg_manual_rts;
         cts_hist.push_front(cts_pin);
         void'(cts_hist.pop_back());
      end
   end

   task automatic chk(input string req, input string what, input bit act, input bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      bit e_cts, e_gate;
      e_cts  = cts_hist[1] ~^ cfg_cts_pol;
      e_gate = cfg_auto_cts ? e_cts : !cfg_tx_pause;
      if (!rst_n) begin
         chk("R5", "rts_n in reset", rts_n, 1'b1);
      end else begin
         chk(cfg_auto_rts ? "R3/R4" : "R2", "rts_n", rts_n, m_rts_n);
         chk("R6", "cts_status", cts_status, e_cts);
         chk("R1", "rx_thr_flag", rx_thr_flag, int'(rx_count) >= thr_now());
         chk(cfg_auto_cts ? "R7" : "R8", "tx_start", tx_start, tx_pending && !tx_busy && e_gate);
         chk("R9", "tx_allow", tx_allow, tx_busy || e_gate);
      end
   end

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic fill(input int lo, input int hi);
      for (int c = lo; c <= hi; c++) begin
         rx_count = CNT_W'(c);
         step();
         rx_start = 1'b1;
         step();
         rx_start = 1'b0;
      end
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      step(3);
      // R5: auto RTS with a full buffer and no start pulse -> ready after reset
      cfg_auto_rts = 1'b1;
      rx_count = 5'd3;
      rst_n = 1'b1;
      step(2);
      // R2: manual control both ways
      cfg_auto_rts = 1'b0;
      cfg_manual_rts = 1'b1; step(2);
      cfg_manual_rts = 1'b0; step(2);
      // R3/R4 threshold two: walk occupancy with start pulses
      cfg_auto_rts = 1'b1;
      rx_count = 5'd0; step(2);
      fill(0, 4);
      rx_count = 5'd3; step(3);   // hold without start
      rx_count = 5'd1; step(2);   // below threshold -> reassert
      // threshold four
      cfg_thr_sel = 1'b1;
      fill(1, 6);
      rx_count = 5'd4; step(2);
      rx_count = 5'd3; step(2);
      rx_start = 1'b1; step(2); rx_start = 1'b0;
      // R1 flag sweep both selections
      for (int s = 0; s < 2; s++) begin
         cfg_thr_sel = s[0];
         for (int c = 0; c < 8; c++) begin
            rx_count = CNT_W'(c);
            step();
         end
      end
      // R6 polarity and synchroniser delay
      for (int p = 0; p < 2; p++) begin
         cfg_cts_pol = p[0];
         cts_pin = 1'b1; step(3);
         cts_pin = 1'b0; step(3);
         cts_pin = 1'b1; step(1);
         cts_pin = 1'b0; step(3);
      end
      // R7 automatic CTS gating
      cfg_cts_pol = 1'b1;
      cfg_auto_cts = 1'b1;
      tx_pending = 1'b1;
      cts_pin = 1'b0; step(3);
      cts_pin = 1'b1; step(3);
      tx_busy = 1'b1; step(2);
      cts_pin = 1'b0; step(3);    // R9: busy word continues
      tx_busy = 1'b0; step(2);
      cfg_tx_pause = 1'b1; cts_pin = 1'b1; step(3); // pause ignored under auto CTS
      // R8 software pause, CTS ignored
      cfg_auto_cts = 1'b0;
      step(2);
      cfg_tx_pause = 1'b0; cts_pin = 1'b0; step(3);
      tx_pending = 1'b0; step(2);
      tx_pending = 1'b1; tx_busy = 1'b1; cfg_tx_pause = 1'b1; step(2);
      tx_busy = 1'b0; step(2);
      // mid-run reset returns pin high
      rst_n = 1'b0; step(2);
      rst_n = 1'b1; step(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule